// File: doc/BRIEF.md
# Hit-Pixel Sparsifying Priority Encoder

This block sits at the edge of a pixel group and finds the pixels that have seen a hit. Each pixel raises its request line for one or more clock cycles. The block latches the request into a pending bit, which stays set until that pixel has been read out. The group hit flag is the OR of all pending bits, so a data acquisition path can tell at once whether the group has anything to send.

Address generation runs only while the loop-back enable is high. Downstream logic lowers this gate to hold off the next word. While the gate is high and a request is pending, the block picks the pending pixel with the lowest index. It raises that pixel's bit in a one-hot acknowledge vector and puts the pixel's binary index on the address output.

A rising edge on the readout strobe releases the acknowledged pixel. Its pending bit is cleared, and in the next cycle the next-lowest pending pixel is presented. New requests keep arriving during readout and are merged into the pending set. They are served by index, not by the order in which they arrived.

Top module: `hitq_sparsifier`

## Requirements
- R1: `hit_o` is high exactly when at least one pixel is pending. A request sampled high on `req_i[i]` at a rising clock edge makes pixel i pending from the cycle after that edge.
- R2: While `loop_en_i` is low, or no pixel is pending, `ack_o` is all zeros and `addr_o` is zero.
- R3: While `loop_en_i` is high and pixels are pending, `addr_o` carries the binary index of the lowest-numbered pending pixel. For example, with pixels 1 and 2 pending it reads 1.
- R4: `ack_o` is one-hot or all zeros. When it is nonzero, bit `addr_o` is the set bit.
- R5: A rising edge of `strobe_i` is a clock edge at which the strobe is sampled high after being sampled low at the previous edge. If such an edge occurs while a pixel is acknowledged, that pixel's pending bit clears, and the next-lowest pending pixel is presented in the following cycle.
- R6: Holding `strobe_i` high over several clock edges releases only one pixel.
- R7: A pending pixel that is not being released stays pending. A request that arrives during readout is served in index order after the current pixel is released, even if its index is lower than that of pixels already waiting.
- R8: If pixel i requests again at the same edge at which it is released, it stays pending.
- R9: After reset, no pixel is pending, `hit_o` is low and the strobe edge history is low.
- R10: A strobe rising edge that occurs while `loop_en_i` is low clears no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | NPIX (256) | Per-pixel hit request, synchronous |
| loop_en_i | input | 1 | Loop-back gate; high allows selection and acknowledge |
| strobe_i | input | 1 | Readout strobe; a rising edge releases the acknowledged pixel |
| hit_o | output | 1 | OR of all pending pixels |
| ack_o | output | NPIX (256) | One-hot acknowledge to the selected pixel |
| addr_o | output | AW (8) | Binary index of the selected pixel |

## Verification
A request shows up on `hit_o` one clock edge after it is sampled. A strobe rise changes the selected address one clock edge after it is sampled. `ack_o` and `addr_o` follow `loop_en_i` within the same cycle, with no register in between. The bench changes inputs just after a falling edge and compares all three outputs with its model at every falling edge. The model updates its pending set at the rising edge and derives the outputs from that set and the present gate, so each result is checked in exactly the cycle in which it is due.

// File: rtl/hitq_pkg.sv
package hitq_pkg;
  parameter int unsigned HQ_NPIX_DEF = 256;

  // mask with bit i set when bit b of index i is one
  function automatic logic [HQ_NPIX_DEF-1:0] hq_index_mask(input int unsigned b);
    logic [HQ_NPIX_DEF-1:0] m;
    for (int unsigned i = 0; i < HQ_NPIX_DEF; i++) begin
      m[i] = ((i >> b) & 1) == 1;
    end
    return m;
  endfunction
endpackage

// File: rtl/hitq_edge.sv
module hitq_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic rise_o
);
  logic strobe_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= strobe_i;
  end

  assign rise_o = strobe_i & ~strobe_q;
endmodule

// File: rtl/hitq_pend.sv
module hitq_pend #(
  parameter int unsigned NPIX = hitq_pkg::HQ_NPIX_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIX-1:0] set_i,
  input  logic [NPIX-1:0] clr_i,
  output logic [NPIX-1:0] pend_o
);
  for (genvar i = 0; i < NPIX; i++) begin : g_bit
    always_ff @(posedge clk_i) begin
      if (!rst_ni) pend_o[i] <= 1'b0;
      else         pend_o[i] <= set_i[i] | (pend_o[i] & ~clr_i[i]);
    end
  end
endmodule

// File: rtl/hitq_pick.sv
module hitq_pick #(
  parameter int unsigned NPIX = hitq_pkg::HQ_NPIX_DEF,
  localparam int unsigned AW = $clog2(NPIX)
) (
  input  logic [NPIX-1:0] pend_i,
  input  logic            loop_en_i,
  output logic            any_o,
  output logic [NPIX-1:0] ack_o,
  output logic [AW-1:0]   addr_o
);
  localparam logic [NPIX-1:0] ONE = {{(NPIX-1){1'b0}}, 1'b1};

  logic [NPIX-1:0] low_oh;
  logic [AW-1:0]   addr_raw;
  logic            grant;

  // isolate the lowest set bit: lowest index wins
  assign low_oh = pend_i & (~pend_i + ONE);
  assign any_o  = |pend_i;
  assign grant  = loop_en_i & any_o;

  for (genvar b = 0; b < AW; b++) begin : g_enc
    localparam logic [NPIX-1:0] MASK = hitq_pkg::hq_index_mask(b);
    assign addr_raw[b] = |(low_oh & MASK);
  end

  assign ack_o  = grant ? low_oh : '0;
  assign addr_o = grant ? addr_raw : '0;
endmodule

// File: rtl/hitq_sparsifier.sv
module hitq_sparsifier #(
  parameter int unsigned NPIX = hitq_pkg::HQ_NPIX_DEF,
  localparam int unsigned AW = $clog2(NPIX)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIX-1:0] req_i,
  input  logic            loop_en_i,
  input  logic            strobe_i,
  output logic            hit_o,
  output logic [NPIX-1:0] ack_o,
  output logic [AW-1:0]   addr_o
);
  logic            stb_rise;
  logic [NPIX-1:0] pend_q;
  logic [NPIX-1:0] release_v;

  hitq_edge i_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .rise_o   (stb_rise)
  );

  assign release_v = ack_o & {NPIX{stb_rise}};

  hitq_pend #(.NPIX(NPIX)) i_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (req_i),
    .clr_i  (release_v),
    .pend_o (pend_q)
  );

  hitq_pick #(.NPIX(NPIX)) i_pick (
    .pend_i    (pend_q),
    .loop_en_i (loop_en_i),
    .any_o     (hit_o),
    .ack_o     (ack_o),
    .addr_o    (addr_o)
  );
endmodule

// File: rtl/hitq_sparsifier_chk.sv
module hitq_sparsifier_chk #(
  parameter int unsigned NPIX = hitq_pkg::HQ_NPIX_DEF,
  localparam int unsigned AW = $clog2(NPIX)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NPIX-1:0] req_i,
  input logic            loop_en_i,
  input logic            hit_o,
  input logic [NPIX-1:0] ack_o,
  input logic [AW-1:0]   addr_o,
  input logic [NPIX-1:0] pend_q,
  input logic            stb_rise
);
  logic started;
  always_ff @(posedge clk_i) begin
    if (!rst_ni) started <= 1'b0;
    else         started <= 1'b1;
  end

  p_hit_follows_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && (|$past(req_i))) |-> hit_o);

  p_gate_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loop_en_i || !hit_o) |-> (ack_o == '0 && addr_o == '0));

  p_lowest_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_o) |-> ((pend_q & ((NPIX'(1) << addr_o) - NPIX'(1))) == '0));

  p_ack_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o));

  p_ack_matches_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_o) |-> ack_o[addr_o]);

  p_release_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_rise && (|ack_o) && !req_i[addr_o]) |=> !pend_q[$past(addr_o)]);

  p_no_loss_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started |-> ((($past(pend_q) & ~$past(ack_o)) & ~pend_q) == '0));
endmodule

bind hitq_sparsifier hitq_sparsifier_chk #(.NPIX(NPIX)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .loop_en_i (loop_en_i),
  .hit_o     (hit_o),
  .ack_o     (ack_o),
  .addr_o    (addr_o),
  .pend_q    (pend_q),
  .stb_rise  (stb_rise)
);

// File: tb/test_hitq_sparsifier.sv
module test_hitq_sparsifier;
  localparam int NPIX = 256;
  localparam int AW   = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NPIX-1:0] req = '0;
  logic            loop_en = 1'b0;
  logic            strobe = 1'b0;
  logic            hit;
  logic [NPIX-1:0] ack;
  logic [AW-1:0]   addr;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string cur_tag = "R9";

  always #4 clk = ~clk;  // 125 MHz

  hitq_sparsifier i_hitq_sparsifier (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .loop_en_i (loop_en),
    .strobe_i (strobe), .hit_o (hit), .ack_o (ack), .addr_o (addr)
  );

  // behavioural reference: a set of waiting pixels and the last strobe level
  bit m_pend [NPIX];
  bit m_stb_prev;

  function automatic int m_lowest();
    for (int i = 0; i < NPIX; i++) if (m_pend[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPIX; i++) m_pend[i] = 1'b0;
      m_stb_prev = 1'b0;
    end else begin
      int w;
      w = m_lowest();
      if (strobe && !m_stb_prev && loop_en && w >= 0) m_pend[w] = 1'b0;
      for (int i = 0; i < NPIX; i++) if (req[i]) m_pend[i] = 1'b1;
      m_stb_prev = strobe;
    end
  end

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      int w;
      logic [NPIX-1:0] exp_ack;
      w = m_lowest();
      exp_ack = '0;
      if (loop_en && w >= 0) exp_ack[w] = 1'b1;
      check(cur_tag, "hit", hit, w >= 0);
      check(cur_tag, "addr", addr, (loop_en && w >= 0) ? w : 0);
      checks++;
      if (ack !== exp_ack) begin
        errors++;
        $display("FAIL %s ack: actual %h expected %h", cur_tag, ack, exp_ack);
      end
    end
  end

  task automatic drive(logic [NPIX-1:0] r, logic l, logic s);
    @(negedge clk); #1;
    req = r; loop_en = l; strobe = s;
  endtask

  function automatic logic [NPIX-1:0] bits2(int a, int b);
    logic [NPIX-1:0] v = '0;
    if (a >= 0) v[a] = 1'b1;
    if (b >= 0) v[b] = 1'b1;
    return v;
  endfunction

  task automatic look(string tag, logic exp_hit, int exp_addr, logic exp_ack_on);
    @(negedge clk);
    check(tag, "hit", hit, exp_hit);
    check(tag, "addr", addr, exp_addr);
    check(tag, "ack set", |ack, exp_ack_on);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (4) @(posedge clk);
    @(negedge clk); #1 rst_n = 1'b1;
    cur_tag = "R9";
    look("R9", 0, 0, 0);

    cur_tag = "R1";
    drive(bits2(1, 2), 0, 0);
    drive('0, 0, 0);
    look("R1", 1, 0, 0);
    look("R2", 1, 0, 0);

    cur_tag = "R3";
    drive('0, 1, 0);
    look("R3", 1, 1, 1);

    cur_tag = "R5";
    drive('0, 1, 1);
    look("R5", 1, 2, 1);

    cur_tag = "R6";
    drive('0, 1, 1);
    drive('0, 1, 1);
    look("R6", 1, 2, 1);

    cur_tag = "R7";
    drive(bits2(0, 200), 1, 1);
    drive('0, 1, 1);
    look("R7", 1, 0, 1);
    drive('0, 1, 0);
    drive('0, 1, 1);
    look("R7", 1, 2, 1);

    cur_tag = "R8";
    drive('0, 1, 0);
    drive(bits2(2, -1), 1, 1);
    drive('0, 1, 1);
    look("R8", 1, 2, 1);

    cur_tag = "R10";
    drive('0, 0, 0);
    drive('0, 0, 1);
    drive('0, 1, 1);
    look("R10", 1, 2, 1);

    cur_tag = "R5";
    drive('0, 1, 0);
    drive('0, 1, 1);
    look("R5", 1, 200, 1);
    drive('0, 1, 0);
    drive('0, 1, 1);
    look("R1", 0, 0, 0);

    cur_tag = "R3";
    drive(bits2(255, 254), 1, 0);
    drive('0, 1, 0);
    look("R3", 1, 254, 1);
    drive('0, 1, 1);
    look("R5", 1, 255, 1);
    drive('0, 1, 0);
    drive('0, 1, 1);
    look("R2", 0, 0, 0);

    // sparse pseudo-random traffic with toggling strobe and gate
    cur_tag = "R4";
    begin
      logic [31:0] lf = 32'hACE1_1234;
      for (int k = 0; k < 400; k++) begin
        logic [NPIX-1:0] r = '0;
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        if (lf[3:0] == 4'd5) r[lf[15:8]] = 1'b1;
        if (lf[7:4] == 4'd9) r[lf[23:16]] = 1'b1;
        drive(r, lf[26:24] != 3'd0, lf[28]);
      end
    end
    drive('0, 1, 0);
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule